// File: doc/BRIEF.md
# Mailbox Receive Slot Allocator

A bank of message slots for a CAN-style controller. Each accepted incoming frame (identifier, extended flag, remote flag, length code and eight data bytes, delivered by a one-cycle strobe) is stored in one slot. The slot is picked by a fixed rule: the lowest-numbered slot in a receive mode that is still empty. A slot that holds a frame stays full until the host re-arms it, so the host reads frames back in arrival order by walking slots upward and re-arming them in groups.

A host register port programs each slot's mode, reads the per-slot full vector, reads a slot's identifier, status and data words, and re-arms any set of slots with one bit-mask write. A slot in overwrite mode takes a frame even when it is full and flags that it lost the older one. A frame that finds no room at all is discarded and a sticky loss bit records it. A per-slot interrupt vector reports full slots under a mask that is changed only by separate set and clear writes.

Top module: `mbx_rx_bank`

## Requirements
- R1: After reset every slot mode is 0 (disabled), no slot is full, the interrupt mask, the loss bit, `irq_vec` and `irq_any` are all zero.
- R2: Each slot's mode register (slot base + 0x00) holds a 3-bit mode in bits 26:24: 0 disabled, 1 receive, 2 receive with overwrite, 3 transmit, 4 consumer, 5 producer; it reads back as written, and writing it empties the slot and clears its overwrite flag.
- R3: A frame is stored in the lowest-numbered slot whose mode is 1 or 2 and which is not full; the global status register (0x010) bit i is 1 exactly when slot i is full.
- R4: A full slot takes no new frame until re-armed; a write to the re-arm register (0x024) empties every slot whose bit is 1 and whose mode is 1 or 2, several at once; bits of slots in other modes are ignored.
- R5: When no slot in mode 1 or 2 is empty, the lowest-numbered mode-2 slot is overwritten with the new frame and its status bit 24 is set; re-arming clears it.
- R6: When no slot in mode 1 or 2 is empty and no slot is in mode 2, the frame is dropped with no slot changed and bit 0 of the loss register (0x014) is set; writing 1 to that bit clears it.
- R7: The identifier word (slot base + 0x08) holds a standard identifier in bits 28:18, or an extended identifier in bits 28:0 with bit 29 set.
- R8: The slot status word (slot base + 0x10) gives full at bit 23, remote flag at bit 20, length code at bits 19:16; data bytes 0-3 read at slot base + 0x14 and bytes 4-7 at + 0x18, byte 0 (and byte 4) in bits 7:0.
- R9: Writing 0x004 sets mask bits, writing 0x008 clears them, 0x00C reads the mask; `irq_vec[i]` is slot i full AND mask bit i, one cycle after either changes, and `irq_any` is their OR.
- R10: Read data appears the cycle after the read strobe with `reg_rvalid` high; unmapped addresses read 0. Slot i's registers start at 0x200 + 0x20*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: a frame is offered |
| frm_ext | input | 1 | Frame carries an extended identifier |
| frm_rtr | input | 1 | Remote frame flag |
| frm_id | input | 29 | Identifier (standard uses bits 10:0) |
| frm_len | input | 4 | Length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | ADDR_W | Host byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid the cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| irq_vec | output | NSLOT | Per-slot interrupt (full and unmasked) |
| irq_any | output | 1 | OR of irq_vec |

## Verification
A wrong full or mode bit shows at once in the global status word and, one cycle later, in `irq_vec`; it also sends the very next frame to the wrong slot, which is visible in that slot's identifier and data words. A corrupted frame store only shows when the affected slot is read, so the bench reads back slot contents after directed fills and throughout the random phase. A lost overwrite flag or loss bit is seen on the next read of the slot status or loss register.

// File: rtl/mbx_rx_pkg.sv
package mbx_rx_pkg;

  localparam logic [2:0] MODE_OFF   = 3'd0;
  localparam logic [2:0] MODE_RX    = 3'd1;
  localparam logic [2:0] MODE_RXOVW = 3'd2;
  localparam logic [2:0] MODE_TX    = 3'd3;
  localparam logic [2:0] MODE_CONS  = 3'd4;
  localparam logic [2:0] MODE_PROD  = 3'd5;

  // global register offsets
  localparam int OFS_MASK_SET = 'h004;
  localparam int OFS_MASK_CLR = 'h008;
  localparam int OFS_MASK     = 'h00C;
  localparam int OFS_FULL     = 'h010;
  localparam int OFS_LOSS     = 'h014;
  localparam int OFS_ARM      = 'h024;

  // slot window
  localparam int SLOT_BASE  = 'h200;
  localparam int STRIDE_SH  = 5;
  localparam logic [4:0] SUB_MODE = 5'h00;
  localparam logic [4:0] SUB_ID   = 5'h08;
  localparam logic [4:0] SUB_STAT = 5'h10;
  localparam logic [4:0] SUB_DLO  = 5'h14;
  localparam logic [4:0] SUB_DHI  = 5'h18;

  typedef struct packed {
    logic [29:0] idw;   // bit 29 extended flag, 28:0 aligned identifier
    logic        rtr;
    logic [3:0]  len;
    logic [63:0] data;
  } mbx_frame_t;

  typedef enum logic [2:0] {
    RK_ZERO, RK_WORD, RK_ID, RK_STAT, RK_DLO, RK_DHI
  } rkind_e;

endpackage

// File: rtl/mbx_slot_pick.sv
module mbx_slot_pick #(
  parameter int NSLOT = 16,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [NSLOT-1:0] rx_en,
  input  logic [NSLOT-1:0] ovw_en,
  input  logic [NSLOT-1:0] full,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             over,
  output logic             drop
);
  logic [NSLOT-1:0] free_vec;
  logic             free_hit, ovw_hit;
  logic [IDX_W-1:0] free_idx, ovw_idx;

  assign free_vec = rx_en & ~full;

  // downward scan: the last match written is the lowest index
  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    ovw_hit  = 1'b0;
    ovw_idx  = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (ovw_en[i]) begin
        ovw_hit = 1'b1;
        ovw_idx = IDX_W'(i);
      end
    end
  end

  assign hit  = free_hit | ovw_hit;
  assign idx  = free_hit ? free_idx : ovw_idx;
  assign over = !free_hit && ovw_hit;
  assign drop = !hit;

endmodule

// File: rtl/mbx_frame_ram.sv
module mbx_frame_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 99,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // read-first synchronous port
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/mbx_slot_state.sv
module mbx_slot_state
  import mbx_rx_pkg::*;
#(
  parameter int NSLOT = 16,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] mode_we,
  input  logic [2:0]       mode_wval,
  input  logic [NSLOT-1:0] arm_vec,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_over,
  output logic [2:0]       mode_q [NSLOT],
  output logic [NSLOT-1:0] rx_en,
  output logic [NSLOT-1:0] ovw_en,
  output logic [NSLOT-1:0] full,
  output logic [NSLOT-1:0] ovf
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit_me;
    assign hit_me    = fill_en && (fill_idx == IDX_W'(g));
    assign rx_en[g]  = (mode_q[g] == MODE_RX) || (mode_q[g] == MODE_RXOVW);
    assign ovw_en[g] = (mode_q[g] == MODE_RXOVW);

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[g] <= MODE_OFF;
        full[g]   <= 1'b0;
        ovf[g]    <= 1'b0;
      end else if (mode_we[g]) begin
        mode_q[g] <= mode_wval;
        full[g]   <= 1'b0;
        ovf[g]    <= 1'b0;
      end else begin
        if (arm_vec[g] && rx_en[g]) begin
          full[g] <= 1'b0;
          ovf[g]  <= 1'b0;
        end
        if (hit_me) begin
          full[g] <= 1'b1;
          if (fill_over) ovf[g] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mbx_rx_bank.sv
module mbx_rx_bank
  import mbx_rx_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic              frm_ext,
  input  logic              frm_rtr,
  input  logic [28:0]       frm_id,
  input  logic [3:0]        frm_len,
  input  logic [63:0]       frm_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic [NSLOT-1:0]  irq_vec,
  output logic              irq_any
);
  localparam int IDX_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int FRM_W    = $bits(mbx_frame_t);
  localparam int SLOT_END = SLOT_BASE + (NSLOT << STRIDE_SH);

  // ---------------- address decode ----------------
  logic              in_slot;
  logic [ADDR_W-1:0] slot_off;
  logic [IDX_W-1:0]  slot_idx;
  logic [4:0]        sub;

  assign in_slot  = (reg_addr >= ADDR_W'(SLOT_BASE)) && (reg_addr < ADDR_W'(SLOT_END));
  assign slot_off = reg_addr - ADDR_W'(SLOT_BASE);
  assign slot_idx = slot_off[STRIDE_SH +: IDX_W];
  assign sub      = reg_addr[4:0];

  logic             glob_wr;
  logic [NSLOT-1:0] mode_we;
  logic             arm_we;
  logic [NSLOT-1:0] arm_vec;

  assign glob_wr = reg_wr && !in_slot;
  assign mode_we = (reg_wr && in_slot && sub == SUB_MODE) ? (NSLOT'(1) << slot_idx) : '0;
  assign arm_we  = glob_wr && (reg_addr == ADDR_W'(OFS_ARM));
  assign arm_vec = arm_we ? reg_wdata[NSLOT-1:0] : '0;

  // ---------------- slot state and picker ----------------
  logic [2:0]       mode_q [NSLOT];
  logic [NSLOT-1:0] rx_en, ovw_en, full, ovf;
  logic             pick_hit, pick_over, pick_drop;
  logic [IDX_W-1:0] pick_idx;
  logic             fill_en;

  mbx_slot_pick #(.NSLOT(NSLOT)) u_pick (
    .rx_en  (rx_en),
    .ovw_en (ovw_en),
    .full   (full),
    .hit    (pick_hit),
    .idx    (pick_idx),
    .over   (pick_over),
    .drop   (pick_drop)
  );

  assign fill_en = frm_valid && pick_hit;

  mbx_slot_state #(.NSLOT(NSLOT)) u_state (
    .clk       (clk),
    .rst       (rst),
    .mode_we   (mode_we),
    .mode_wval (reg_wdata[26:24]),
    .arm_vec   (arm_vec),
    .fill_en   (fill_en),
    .fill_idx  (pick_idx),
    .fill_over (pick_over),
    .mode_q    (mode_q),
    .rx_en     (rx_en),
    .ovw_en    (ovw_en),
    .full      (full),
    .ovf       (ovf)
  );

  // ---------------- frame store ----------------
  mbx_frame_t       wr_frame, rd_frame;
  logic [FRM_W-1:0] rd_raw;
  logic             mem_rd;

  always_comb begin
    wr_frame.idw  = frm_ext ? {1'b1, frm_id} : {1'b0, frm_id[10:0], 18'b0};
    wr_frame.rtr  = frm_rtr;
    wr_frame.len  = frm_len;
    wr_frame.data = frm_data;
  end

  assign mem_rd = reg_rd && in_slot;

  mbx_frame_ram #(.DEPTH(NSLOT), .WIDTH(FRM_W)) u_ram (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_addr (pick_idx),
    .wr_data (wr_frame),
    .rd_en   (mem_rd),
    .rd_addr (slot_idx),
    .rd_data (rd_raw)
  );

  assign rd_frame = mbx_frame_t'(rd_raw);

  // ---------------- mask, loss, interrupts ----------------
  logic [NSLOT-1:0] mask_q;
  logic             loss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      loss_q  <= 1'b0;
      irq_vec <= '0;
      irq_any <= 1'b0;
    end else begin
      if (glob_wr && reg_addr == ADDR_W'(OFS_MASK_SET)) mask_q <= mask_q | reg_wdata[NSLOT-1:0];
      else if (glob_wr && reg_addr == ADDR_W'(OFS_MASK_CLR)) mask_q <= mask_q & ~reg_wdata[NSLOT-1:0];
      if (frm_valid && pick_drop) loss_q <= 1'b1;
      else if (glob_wr && reg_addr == ADDR_W'(OFS_LOSS) && reg_wdata[0]) loss_q <= 1'b0;
      irq_vec <= full & mask_q;
      irq_any <= |(full & mask_q);
    end
  end

  // ---------------- read path ----------------
  rkind_e      rkind_d, rkind_q;
  logic [31:0] rword_d, rword_q;
  logic [1:0]  rflag_d, rflag_q;

  always_comb begin
    rkind_d = RK_ZERO;
    rword_d = '0;
    rflag_d = '0;
    if (in_slot) begin
      unique case (sub)
        SUB_MODE: begin rkind_d = RK_WORD; rword_d = {5'b0, mode_q[slot_idx], 24'b0}; end
        SUB_ID:   rkind_d = RK_ID;
        SUB_STAT: begin rkind_d = RK_STAT; rflag_d = {ovf[slot_idx], full[slot_idx]}; end
        SUB_DLO:  rkind_d = RK_DLO;
        SUB_DHI:  rkind_d = RK_DHI;
        default:  rkind_d = RK_ZERO;
      endcase
    end else begin
      if (reg_addr == ADDR_W'(OFS_MASK)) begin
        rkind_d = RK_WORD; rword_d = 32'(mask_q);
      end else if (reg_addr == ADDR_W'(OFS_FULL)) begin
        rkind_d = RK_WORD; rword_d = 32'(full);
      end else if (reg_addr == ADDR_W'(OFS_LOSS)) begin
        rkind_d = RK_WORD; rword_d = {31'b0, loss_q};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      rkind_q    <= RK_ZERO;
      rword_q    <= '0;
      rflag_q    <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        rkind_q <= rkind_d;
        rword_q <= rword_d;
        rflag_q <= rflag_d;
      end
    end
  end

  always_comb begin
    unique case (rkind_q)
      RK_WORD: reg_rdata = rword_q;
      RK_ID:   reg_rdata = {2'b0, rd_frame.idw};
      RK_STAT: reg_rdata = {7'b0, rflag_q[1], rflag_q[0], 2'b0, rd_frame.rtr, rd_frame.len, 16'b0};
      RK_DLO:  reg_rdata = rd_frame.data[31:0];
      RK_DHI:  reg_rdata = rd_frame.data[63:32];
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbx_rx_bank_chk.sv
module mbx_rx_bank_chk #(
  parameter int NSLOT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             frm_valid,
  input logic             pick_drop,
  input logic             loss_q,
  input logic [NSLOT-1:0] full,
  input logic [NSLOT-1:0] rx_en,
  input logic [NSLOT-1:0] mask_q,
  input logic [NSLOT-1:0] irq_vec,
  input logic [NSLOT-1:0] mode_we,
  input logic             arm_we,
  input logic             reg_rd,
  input logic             reg_rvalid
);

  // R6: a dropped frame leaves the loss bit set
  a_r6_drop_sets_loss: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && pick_drop) |=> loss_q);

  // R6: a dropped frame changes no slot
  a_r6_drop_keeps_slots: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && pick_drop && mode_we == '0 && !arm_we) |=> (full == $past(full)));

  // R2: only receive-mode slots can be full
  a_r2_full_needs_rx: assert property (@(posedge clk) disable iff (rst)
    ((full & ~rx_en) == '0));

  // R3: at most one slot fills per cycle
  a_r3_one_fill: assert property (@(posedge clk) disable iff (rst)
    ($countones(full & ~$past(full)) <= 1));

  // R9: no interrupt on a masked slot
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
    ((irq_vec & ~$past(mask_q)) == '0));

  // R10: every read returns data one cycle later
  a_r10_rvalid: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

endmodule

bind mbx_rx_bank mbx_rx_bank_chk #(.NSLOT(NSLOT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frm_valid  (frm_valid),
  .pick_drop  (pick_drop),
  .loss_q     (loss_q),
  .full       (full),
  .rx_en      (rx_en),
  .mask_q     (mask_q),
  .irq_vec    (irq_vec),
  .mode_we    (mode_we),
  .arm_we     (arm_we),
  .reg_rd     (reg_rd),
  .reg_rvalid (reg_rvalid)
);

// File: tb/mbx_rx_bank_bench.sv
`timescale 1ns/1ps
module mbx_rx_bank_bench;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_len = '0;
  logic [63:0] frm_data = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [NS-1:0] irq_vec;
  logic        irq_any;

  always #2.5 clk = ~clk;

  mbx_rx_bank #(.NSLOT(NS), .ADDR_W(12)) u_mbx_rx_bank (
    .clk(clk), .rst(rst),
    .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
    .frm_id(frm_id), .frm_len(frm_len), .frm_data(frm_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq_vec(irq_vec), .irq_any(irq_any)
  );

  // ---------------- model ----------------
  logic [2:0]  m_mode [NS];
  bit          m_full [NS];
  bit          m_ovf  [NS];
  bit          m_wr   [NS];
  logic [31:0] m_id   [NS];
  bit          m_rtr  [NS];
  logic [3:0]  m_len  [NS];
  logic [63:0] m_data [NS];
  logic [NS-1:0] m_mask;
  bit          m_loss;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [NS-1:0] full_vec();
    logic [NS-1:0] v;
    for (int i = 0; i < NS; i++) v[i] = m_full[i];
    return v;
  endfunction

  function automatic bit is_rx(int i);
    return (m_mode[i] == 3'd1) || (m_mode[i] == 3'd2);
  endfunction

  function automatic logic [11:0] sa(int i, int s);
    return 12'(32'h200 + i * 32 + s);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 12'h004) m_mask = m_mask | d[NS-1:0];
    else if (a == 12'h008) m_mask = m_mask & ~d[NS-1:0];
    else if (a == 12'h014) begin if (d[0]) m_loss = 0; end
    else if (a == 12'h024) begin
      for (int i = 0; i < NS; i++)
        if (d[i] && is_rx(i)) begin m_full[i] = 0; m_ovf[i] = 0; end
    end else if (a >= 12'h200 && a < 12'h400 && a[4:0] == 5'd0) begin
      m_mode[(a - 12'h200) >> 5] = d[26:24];
      m_full[(a - 12'h200) >> 5] = 0;
      m_ovf[(a - 12'h200) >> 5]  = 0;
    end
  endtask

  task automatic host_rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata; v = reg_rvalid;
    reg_rd = 1'b0;
  endtask

  task automatic send(input bit ext, input bit rtr, input logic [28:0] id,
                      input logic [3:0] len, input logic [63:0] dat);
    int tgt;
    bit over;
    tgt = -1; over = 0;
    for (int i = NS - 1; i >= 0; i--) if (is_rx(i) && !m_full[i]) tgt = i;
    if (tgt < 0) begin
      for (int i = NS - 1; i >= 0; i--) if (m_mode[i] == 3'd2) tgt = i;
      over = (tgt >= 0);
    end
    frm_valid = 1'b1; frm_ext = ext; frm_rtr = rtr; frm_id = id; frm_len = len; frm_data = dat;
    @(negedge clk);
    frm_valid = 1'b0;
    if (tgt < 0) m_loss = 1;
    else begin
      m_full[tgt] = 1; if (over) m_ovf[tgt] = 1;
      m_wr[tgt] = 1;
      m_id[tgt] = ext ? {2'b0, 1'b1, id} : {3'b0, id[10:0], 18'b0};
      m_rtr[tgt] = rtr; m_len[tgt] = len; m_data[tgt] = dat;
    end
  endtask

  task automatic check_glob(input string tag);
    logic [31:0] d; logic v;
    @(negedge clk);
    chk({tag, " R9 irq_vec"}, 64'(irq_vec), 64'(full_vec() & m_mask));
    chk({tag, " R9 irq_any"}, 64'(irq_any), 64'(|(full_vec() & m_mask)));
    host_rd(12'h010, d, v);
    chk({tag, " R3 full vector"}, 64'(d), 64'(full_vec()));
  endtask

  task automatic check_slot(input string tag, input int i);
    logic [31:0] d; logic v;
    host_rd(sa(i, 0), d, v);
    chk({tag, " R2 mode"}, 64'(d), 64'({5'b0, m_mode[i], 24'b0}));
    if (m_wr[i]) begin
      host_rd(sa(i, 'h10), d, v);
      chk({tag, " R8 status"}, 64'(d),
          64'({7'b0, m_ovf[i], m_full[i], 2'b0, m_rtr[i], m_len[i], 16'b0}));
      host_rd(sa(i, 'h08), d, v);
      chk({tag, " R7 id"}, 64'(d), 64'(m_id[i]));
      host_rd(sa(i, 'h14), d, v);
      chk({tag, " R8 data lo"}, 64'(d), 64'(m_data[i][31:0]));
      host_rd(sa(i, 'h18), d, v);
      chk({tag, " R8 data hi"}, 64'(d), 64'(m_data[i][63:32]));
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    int unsigned seed;
    for (int i = 0; i < NS; i++) begin
      m_mode[i] = 0; m_full[i] = 0; m_ovf[i] = 0; m_wr[i] = 0;
      m_id[i] = 0; m_rtr[i] = 0; m_len[i] = 0; m_data[i] = 0;
    end
    m_mask = '0; m_loss = 0;
    seed = 32'h1234_abcd;
    void'($urandom(seed));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    host_rd(12'h010, d, v); chk("R1 full vector", 64'(d), 64'h0);
    host_rd(12'h00C, d, v); chk("R1 mask", 64'(d), 64'h0);
    host_rd(12'h014, d, v); chk("R1 loss", 64'(d), 64'h0);
    host_rd(sa(3, 0), d, v); chk("R1 mode", 64'(d), 64'h0);
    chk("R1 irq", 64'({irq_any, irq_vec}), 64'h0);

    // R2 configure: 0..10 receive, 11 overwrite, 12..15 transmit
    for (int i = 0; i < 11; i++) host_wr(sa(i, 0), 32'h0100_0000);
    host_wr(sa(11, 0), 32'h0200_0000);
    for (int i = 12; i < NS; i++) host_wr(sa(i, 0), 32'h0300_0000);
    host_rd(sa(11, 0), d, v); chk("R2 mode readback", 64'(d), 64'h0200_0000);

    // R10 read timing and unmapped
    host_rd(12'h100, d, v);
    chk("R10 unmapped zero", 64'(d), 64'h0);
    chk("R10 rvalid", 64'(v), 64'h1);

    // R3/R7/R8 standard and extended frames
    send(0, 1, 29'h123, 4'd5, 64'h8877_6655_4433_2211);
    send(1, 0, 29'h1abc_def0, 4'd8, 64'hdead_beef_0bad_f00d);
    check_glob("dir1");
    check_slot("dir1 s0", 0);
    check_slot("dir1 s1", 1);

    // R4 re-arm slot 0, next frame lands there
    host_wr(12'h024, 32'h0000_0001);
    check_glob("dir2 after arm");
    send(0, 0, 29'h7ff, 4'd2, 64'h0000_0000_0000_abcd);
    check_slot("dir2 R3 lowest", 0);

    // fill 2..11, then R5 overwrite of slot 11
    for (int i = 2; i < 12; i++) send(0, 0, 29'(i), 4'(i % 9), {32'(i), 32'(~i)});
    check_glob("dir3 all full");
    check_slot("dir3 s11 pre", 11);
    send(1, 1, 29'h0555_0555, 4'd7, 64'h1111_2222_3333_4444);
    check_slot("dir3 R5 overwrite", 11);
    host_wr(12'h024, 32'h0000_0800);
    check_slot("dir3 R5 rearm clears", 11);
    send(0, 0, 29'h42, 4'd1, 64'h99);
    check_slot("dir3 R3 refill", 11);

    // R6 drop: disable overwrite slot, bank full
    host_wr(sa(11, 0), 32'h0);
    host_wr(sa(10, 0), 32'h0100_0000);
    send(0, 0, 29'h0aa, 4'd3, 64'h5a5a);
    send(0, 0, 29'h0bb, 4'd3, 64'h6b6b);
    host_wr(sa(11, 0), 32'h0000_0000);
    send(0, 0, 29'h0cc, 4'd4, 64'h7c7c);
    host_rd(12'h014, d, v); chk("R6 loss set", 64'(d), 64'h1);
    check_glob("dir4 R6 no slot change");
    check_slot("dir4 R6 s10 kept", 10);
    host_wr(12'h014, 32'h1);
    host_rd(12'h014, d, v); chk("R6 loss cleared", 64'(d), 64'h0);

    // R4 re-arm several, transmit bits ignored
    host_wr(12'h024, 32'h0000_f008 | 32'h0000_0010);
    check_glob("dir5 R4 multi arm");
    check_slot("dir5 R4 tx mode kept", 12);

    // R9 mask set / clear
    host_wr(12'h004, 32'h0000_00ff);
    check_glob("dir6 R9 set");
    host_wr(12'h008, 32'h0000_0002);
    host_rd(12'h00C, d, v); chk("R9 mask read", 64'(d), 64'(m_mask));
    check_glob("dir6 R9 clear");

    // random phase
    for (int it = 0; it < 500; it++) begin
      int op;
      int s;
      op = int'($urandom % 100);
      s  = int'($urandom % NS);
      if (op < 50) begin
        send(1'($urandom), 1'($urandom), 29'($urandom), 4'($urandom), {$urandom, $urandom});
      end else if (op < 68) begin
        host_wr(12'h024, $urandom & 32'hffff);
      end else if (op < 78) begin
        host_wr(sa(s, 0), {5'b0, 3'($urandom % 6), 24'b0});
      end else if (op < 86) begin
        host_wr(($urandom % 2) ? 12'h004 : 12'h008, $urandom & 32'hffff);
      end else if (op < 90) begin
        host_wr(12'h014, 32'h1);
      end else begin
        check_slot("rnd", s);
        host_rd(12'h014, d, v); chk("rnd R6 loss", 64'(d), 64'(m_loss));
      end
      check_glob("rnd");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule